// File: doc/BRIEF.md
# Configuration-Byte Read Window Controller

This block sits beside a small CPU's program-memory load path and a bank of non-volatile configuration bits. Software writes a self-programming control register, setting an enable bit together with a read-configuration bit. For a short window after that write, a program-memory load instruction returns a configuration byte picked by the 16-bit address pointer instead of program memory. The window closes by itself when the read is served or when the window runs out.

A busy EEPROM write blocks both the control-register write and the configuration read. When the enable bit is written without the read-configuration bit, the block holds a store window. That window closes on the first store instruction or after its own cycle budget. The flash programming itself is handled elsewhere.

Top module: `cfg_read_window`

## Requirements
- R1: After reset both control bits are clear and `ctl_rdata` reads 0x00.
- R2: `ctl_rdata` bit 0 is the enable bit and bit 3 is the read-configuration bit; bit 3 is only stored when the same write also sets bit 0; every other bit reads 0.
- R3: With both bits set, a load strobe in any of the first three cycles after the arming write edge returns the configuration byte on `ld_data` in that same cycle.
- R4: While armed, pointer 0x0000 selects the low fuse byte, 0x0001 the lock byte, 0x0003 the high fuse byte, and any other value returns 0xFF.
- R5: The fuse and lock inputs flag programmed bits with 1. Programmed bits read as 0 and unprogrammed bits read as 1. The two lock bits sit in bits 1:0 of the lock byte, and bits 7:2 read as 1.
- R6: A served configuration read clears both control bits at the clock edge that ends the load cycle.
- R7: With no load, both bits clear at the third clock edge after the arming write, and a load after that returns program memory.
- R8: With only the enable bit written, the bit clears on a store strobe, or at the fourth clock edge after the write when no store comes.
- R9: While the read-configuration bit is clear, `ld_data` equals `pmem_data`.
- R10: While `ee_busy` is high, control-register writes are ignored. Loads return program memory and do not end the window.
- R11: A new accepted write during a window restarts its cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control-register write data |
| ld_strobe | input | 1 | Program-memory load instruction strobe |
| st_strobe | input | 1 | Store instruction strobe |
| zptr | input | 16 | Address pointer |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_lo_prog | input | 8 | Low fuse byte, 1 = programmed |
| fuse_hi_prog | input | 8 | High fuse byte, 1 = programmed |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| pmem_data | input | 8 | Normal program-memory load data |
| ld_data | output | 8 | Load result |
| ctl_rdata | output | 8 | Control register read value |

## Verification
The assertions watch several properties on every cycle. The read-configuration bit never stands without the enable bit. Loads pass program memory through whenever the block is not armed. A served read clears the register. A busy write cannot set the enable bit. The enable bit never outlives the store budget. The bench scenarios cover the rest: the address decode, the inversion of programmed bits, and the exact edge at which each window expires. They also show that a rewrite restarts the count and that a blocked load leaves the window open.

// File: rtl/cfg_read_window.sv
module cfg_read_window #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4,
  parameter int ZW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          ld_strobe,
  input  logic          st_strobe,
  input  logic [ZW-1:0] zptr,
  input  logic          ee_busy,
  input  logic [7:0]    fuse_lo_prog,
  input  logic [7:0]    fuse_hi_prog,
  input  logic [1:0]    lock_prog,
  input  logic [7:0]    pmem_data,
  output logic [7:0]    ld_data,
  output logic [7:0]    ctl_rdata
);
  localparam int CW = $clog2(LD_WIN + ST_WIN + 1);

  logic          en_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cfg_byte;

  wire wr_ok  = ctl_we & ~ee_busy;
  wire hit    = rd_q & ld_strobe & ~ee_busy;
  wire rd_end = rd_q & (hit | (cnt_q == CW'(LD_WIN - 1)));
  wire st_end = en_q & ~rd_q & (st_strobe | (cnt_q == CW'(ST_WIN - 1)));
  wire unused_bits = ^{ctl_wdata[7:4], ctl_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else if (wr_ok) begin
      en_q  <= ctl_wdata[0];
      rd_q  <= ctl_wdata[0] & ctl_wdata[3];
      cnt_q <= '0;
    end else if (rd_end | st_end) begin
      en_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else if (en_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (zptr)
      ZW'(0):  cfg_byte = ~fuse_lo_prog;
      ZW'(1):  cfg_byte = {6'h3F, ~lock_prog};
      ZW'(3):  cfg_byte = ~fuse_hi_prog;
      default: cfg_byte = 8'hFF;
    endcase
  end

  assign ld_data   = hit ? cfg_byte : pmem_data;
  assign ctl_rdata = {4'b0, rd_q, 2'b0, en_q};
endmodule

// File: rtl/cfg_read_window_chk.sv
module cfg_read_window_chk #(
  parameter int ST_WIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic       ee_busy,
  input logic       ld_strobe,
  input logic [7:0] pmem_data,
  input logic [7:0] ld_data,
  input logic [7:0] ctl_rdata
);
  logic [7:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  live_q <= '0;
    else if (ctl_we && !ee_busy) live_q <= '0;
    else if (ctl_rdata[0])       live_q <= live_q + 1'b1;
    else                         live_q <= '0;
  end

  // R2
  rd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3] |-> ctl_rdata[0]);

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[3] |-> ld_data == pmem_data);

  // R6
  served_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[3] && ld_strobe && !ee_busy && !ctl_we) |=> ctl_rdata == 8'h00);

  // R10
  busy_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_busy && !ctl_rdata[0]) |=> !ctl_rdata[0]);

  // R8
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] |-> live_q < 8'(ST_WIN));
endmodule

bind cfg_read_window cfg_read_window_chk #(.ST_WIN(ST_WIN)) u_chk (.*);

// File: tb/tb_cfg_read_window.sv
module tb_cfg_read_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PMEM = 8'h5A;
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'hCA}, {16'h0001, 8'hFD}, {16'h0003, 8'hF0},
    {16'h0002, 8'hFF}, {16'h0100, 8'hFF}, {16'hFFFF, 8'hFF}
  };

  logic clk = 0, rst_n = 0, ctl_we = 0, ld_strobe = 0, st_strobe = 0, ee_busy = 0;
  logic [7:0] ctl_wdata = 0, ld_data, ctl_rdata;
  logic [15:0] zptr = 0;
  int tests = 0, fails = 0;

  cfg_read_window dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ld_strobe(ld_strobe), .st_strobe(st_strobe), .zptr(zptr), .ee_busy(ee_busy),
    .fuse_lo_prog(8'h35), .fuse_hi_prog(8'h0F), .lock_prog(2'b10),
    .pmem_data(PMEM), .ld_data(ld_data), .ctl_rdata(ctl_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    ld_strobe = 1; #1;
    chk("R1 reset ctl", ctl_rdata, 8'h00);
    chk("R9 reset load", ld_data, PMEM);
    ld_strobe = 0; rst_n = 1;

    // R3 R4 R5 R6: decode table
    foreach (VEC[i]) begin
      wr(8'h09);
      chk("R2 armed ctl", ctl_rdata, 8'h09);
      zptr = VEC[i][23:8]; ld_strobe = 1; #1;
      chk("R4 R5 decode", ld_data, VEC[i][7:0]);
      @(negedge clk); ld_strobe = 0;
      chk("R6 served clear", ctl_rdata, 8'h00);
    end

    // R3 R7: last cycle of window still hits, then expiry
    wr(8'h09); zptr = 16'h0000;
    @(negedge clk); @(negedge clk);
    chk("R7 still armed C2", ctl_rdata, 8'h09);
    ld_strobe = 1; #1;
    chk("R3 hit in third cycle", ld_data, 8'hCA);
    ld_strobe = 0;
    wr(8'h09);
    repeat (3) @(negedge clk);
    chk("R7 timeout clear", ctl_rdata, 8'h00);
    ld_strobe = 1; #1;
    chk("R7 load after timeout", ld_data, PMEM);
    ld_strobe = 0;

    // R2: read bit alone, extra bits
    wr(8'h08);
    chk("R2 rd alone", ctl_rdata, 8'h00);
    wr(8'hFF);
    chk("R2 other bits", ctl_rdata, 8'h09);
    repeat (3) @(negedge clk);

    // R8: store-only window
    wr(8'h01);
    repeat (3) @(negedge clk);
    chk("R8 store C3", ctl_rdata, 8'h01);
    ld_strobe = 1; #1;
    chk("R9 store mode load", ld_data, PMEM);
    ld_strobe = 0;
    @(negedge clk);
    chk("R8 store timeout", ctl_rdata, 8'h00);
    wr(8'h01);
    st_strobe = 1; @(negedge clk); st_strobe = 0;
    chk("R8 store clears", ctl_rdata, 8'h00);

    // R10: busy interlock
    ee_busy = 1;
    wr(8'h09);
    chk("R10 busy write", ctl_rdata, 8'h00);
    ee_busy = 0;
    wr(8'h09);
    ee_busy = 1; ld_strobe = 1; #1;
    chk("R10 busy load", ld_data, PMEM);
    @(negedge clk); ld_strobe = 0; ee_busy = 0;
    chk("R10 window kept", ctl_rdata, 8'h09);
    repeat (2) @(negedge clk);

    // R11: rewrite restarts count
    wr(8'h09);
    @(negedge clk);
    wr(8'h09);
    @(negedge clk);
    chk("R11 restarted", ctl_rdata, 8'h09);
    repeat (2) @(negedge clk);
    chk("R11 expired", ctl_rdata, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule